// File: doc/BRIEF.md
# Orbit Period Meter with History Queue

This block watches the orbit pulses of one output channel. It measures the spacing between consecutive pulses in bunch-clock ticks, where one tick is one cycle of `clk`. The newest measurement is held in a register. Every measurement is also pushed into a history queue that keeps the most recent `DEPTH` entries; when the queue is full, the oldest entry is discarded so that a new one can be stored. A read port returns the oldest stored entry and removes it when the read strobe is given.

A second function counts orbit pulses in a wrapping counter. The period measurement and the pulse counter each have a level enable and a one-cycle clear strobe.

The measured value is always one more than the true tick distance between two pulses. After a clear strobe, counting starts at the strobe rather than at a pulse, so the first stored value does not describe a real orbit.

Top module: `orbit_period_meter`

## Requirements
- R1: After reset, `last_period` is 0, `pulse_count` is 0, `q_empty` is 1, `q_full` is 0, and bit PW of `rd_word` is 1.
- R2: For two orbit pulses sampled d edges apart while `per_en` is 1, the stored period is d+1. This value appears in `last_period` one cycle after the second pulse and is also pushed into the queue.
- R3: The queue returns entries oldest first. `q_full` is 1 exactly when DEPTH entries are stored, and `q_empty` is 1 exactly when none are stored.
- R4: `rd_word[PW-1:0]` is the oldest stored period. `rd_word[PW]` is 1 when that entry is the only one left or the queue is empty. An empty queue reads as data 0 with the flag set, and a read strobe on an empty queue changes nothing.
- R5: A period measured while the queue is full discards the oldest entry, and the queue stays full.
- R6: `per_clr` empties the queue, sets `last_period` to 0 and restarts the tick counter. A pulse sampled k edges after the clear edge stores the value k.
- R7: While `per_en` is 0, pulses store nothing: `last_period` and the queue are unchanged.
- R8: The period saturates at 2^PW-1 when pulses are further apart than that.
- R9: `pulse_count` increments on each sampled pulse while `cnt_en` is 1, holds while `cnt_en` is 0, and `cnt_clr` sets it to 0.
- R10: `pulse_count` wraps from 2^CW-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| orbit_pulse | input | 1 | Orbit output pulse, one cycle wide |
| per_en | input | 1 | Enables the period measurement |
| per_clr | input | 1 | Strobe: clears the tick counter, queue and last period |
| cnt_en | input | 1 | Enables the pulse counter |
| cnt_clr | input | 1 | Strobe: clears the pulse counter |
| q_rd | input | 1 | Strobe: removes the oldest queue entry |
| last_period | output | PW | Newest measured period |
| rd_word | output | PW+1 | Oldest queue entry with the last-or-empty flag in bit PW |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds DEPTH entries |
| pulse_count | output | CW | Orbit pulse count |

## Verification
The bench builds the block with DEPTH=4, PW=8 and CW=8. A four-entry queue fills after a handful of pulses, which exercises overwrite of the oldest entry and the flag on the last entry. An 8-bit period saturates after a 300-tick gap. An 8-bit pulse counter wraps after 256 pulses, all within a short run.

// File: rtl/orbit_period_meter.sv
module orbit_period_meter #(
  parameter int DEPTH = 256,
  parameter int PW    = 14,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          orbit_pulse,
  input  logic          per_en,
  input  logic          per_clr,
  input  logic          cnt_en,
  input  logic          cnt_clr,
  input  logic          q_rd,
  output logic [PW-1:0] last_period,
  output logic [PW:0]   rd_word,
  output logic          q_empty,
  output logic          q_full,
  output logic [CW-1:0] pulse_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PMAX = '1;
  localparam logic [AW:0] FULLN = AW'(0) + (AW+1)'(DEPTH);

  logic [PW-1:0] ticks;
  logic [PW-1:0] ticks_inc;
  logic [PW-1:0] store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic push, pop, rp_adv;

  assign ticks_inc = (ticks == PMAX) ? PMAX : ticks + 1'b1;
  assign push      = orbit_pulse & per_en & ~per_clr;
  assign pop       = q_rd & ~q_empty & ~per_clr;
  assign rp_adv    = pop | (push & q_full);
  assign q_empty   = (fill == '0);
  assign q_full    = (fill == FULLN);
  assign rd_word   = {(fill <= (AW+1)'(1)), (q_empty ? '0 : store[rp])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks       <= '0;
      last_period <= '0;
    end else if (per_clr || !per_en) begin
      ticks <= '0;
      if (per_clr) last_period <= '0;
    end else if (orbit_pulse) begin
      ticks       <= PW'(1);
      last_period <= ticks_inc;
    end else begin
      ticks <= ticks_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= ticks_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (per_clr) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push)   wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rp_adv) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, rp_adv})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pulse_count <= '0;
    else if (cnt_clr)             pulse_count <= '0;
    else if (cnt_en && orbit_pulse) pulse_count <= pulse_count + 1'b1;
  end
endmodule

module orbit_period_meter_chk #(
  parameter int PW = 14,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          orbit_pulse,
  input logic          per_en,
  input logic          per_clr,
  input logic          cnt_en,
  input logic          cnt_clr,
  input logic          q_rd,
  input logic [PW-1:0] last_period,
  input logic [PW:0]   rd_word,
  input logic          q_empty,
  input logic          q_full,
  input logic [CW-1:0] pulse_count
);
  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_empty, q_full}));

  // R4
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> rd_word[PW]);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_clr |=> (q_empty && last_period == '0));

  // R2
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (orbit_pulse && per_en && !per_clr) |=> !q_empty);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_en && !per_clr && !q_rd) |=> ($stable(last_period) && $stable(q_empty)));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> $stable(pulse_count));
endmodule

bind orbit_period_meter orbit_period_meter_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .orbit_pulse(orbit_pulse), .per_en(per_en),
  .per_clr(per_clr), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .q_rd(q_rd),
  .last_period(last_period), .rd_word(rd_word), .q_empty(q_empty),
  .q_full(q_full), .pulse_count(pulse_count)
);

// File: tb/sim_orbit_period_meter.sv
module sim_orbit_period_meter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic orb = 1'b0, per_en = 1'b1, per_clr = 1'b0, cnt_en = 1'b1, cnt_clr = 1'b0, q_rd = 1'b0;
  logic [PW-1:0] last_period;
  logic [PW:0]   rd_word;
  logic          q_empty, q_full;
  logic [CW-1:0] pulse_count;

  int checks = 0, errors = 0;
  int exp_q[$];
  int exp_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  orbit_period_meter #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .orbit_pulse(orb), .per_en(per_en),
    .per_clr(per_clr), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .q_rd(q_rd),
    .last_period(last_period), .rd_word(rd_word), .q_empty(q_empty),
    .q_full(q_full), .pulse_count(pulse_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pulse d edges after the previous pulse (or clear edge); expected value pushed
  task automatic pulse_gap(input int d, input int expv);
    repeat (d-1) @(negedge clk);
    orb = 1'b1;
    @(negedge clk);
    orb = 1'b0;
    if (per_en) begin
      exp_q.push_back(expv);
      if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
    end
    if (cnt_en) exp_cnt = (exp_cnt + 1) % (1 << CW);
  endtask

  task automatic clear_period();
    per_clr = 1'b1;
    @(negedge clk);
    per_clr = 1'b0;
    exp_q.delete();
  endtask

  // monitor: pop expected items and compare against the read port
  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      chk(rd_word[PW-1:0] == PW'(e), req, int'(rd_word[PW-1:0]), e);
      chk(rd_word[PW] == (exp_q.size() == 0), "R4 last flag", int'(rd_word[PW]), int'(exp_q.size() == 0));
      q_rd = 1'b1;
      @(negedge clk);
      q_rd = 1'b0;
    end
    chk(q_empty == 1'b1, "R3 empty after drain", int'(q_empty), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(last_period == 0, "R1 last_period", int'(last_period), 0);
    chk(pulse_count == 0, "R1 pulse_count", int'(pulse_count), 0);
    chk(q_empty == 1 && q_full == 0, "R1 flags", int'({q_empty, q_full}), 2);
    chk(rd_word[PW] == 1, "R1 rd flag", int'(rd_word[PW]), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 first sample from clear, R2 d+1 periods
    clear_period();
    pulse_gap(5, 5);
    pulse_gap(10, 11);
    pulse_gap(3, 4);
    chk(last_period == 4, "R2 last_period", int'(last_period), 4);
    chk(pulse_count == CW'(exp_cnt), "R9 count", int'(pulse_count), exp_cnt);
    drain("R2 queue value");
    // R4 empty read
    chk(rd_word == {1'b1, {PW{1'b0}}}, "R4 empty word", int'(rd_word), 1 << PW);
    q_rd = 1'b1; @(negedge clk); q_rd = 1'b0;
    chk(q_empty == 1 && rd_word[PW] == 1, "R4 empty read no effect", int'(q_empty), 1);

    // R3/R5 fill past depth
    clear_period();
    pulse_gap(1, 1);
    for (int g = 2; g <= 6; g++) pulse_gap(g, g + 1);
    chk(q_full == 1, "R3 full", int'(q_full), 1);
    drain("R5 overwrite order");

    // R8 saturation
    clear_period();
    pulse_gap(2, 2);
    pulse_gap(300, PMAX);
    chk(last_period == PW'(PMAX), "R8 saturate", int'(last_period), PMAX);
    chk(q_empty == 0, "R2 stored", int'(q_empty), 0);
    // R6 clear with entries present
    clear_period();
    chk(q_empty == 1 && last_period == 0, "R6 clear", int'(last_period), 0);

    // R7 disabled measurement
    per_en = 1'b0;
    pulse_gap(4, 0);
    pulse_gap(4, 0);
    chk(q_empty == 1, "R7 no push", int'(q_empty), 1);
    chk(last_period == 0, "R7 last_period held", int'(last_period), 0);
    chk(pulse_count == CW'(exp_cnt), "R9 count with per_en low", int'(pulse_count), exp_cnt);

    // R9 counter disable and clear
    cnt_en = 1'b0;
    pulse_gap(2, 0);
    pulse_gap(2, 0);
    chk(pulse_count == CW'(exp_cnt), "R9 hold", int'(pulse_count), exp_cnt);
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    exp_cnt = 0;
    chk(pulse_count == 0, "R9 clear", int'(pulse_count), 0);

    // R10 wrap
    cnt_en = 1'b1;
    for (int i = 0; i < (1 << CW); i++) pulse_gap(1, 0);
    chk(pulse_count == 0, "R10 wrap", int'(pulse_count), 0);
    pulse_gap(1, 0);
    chk(pulse_count == 1, "R10 after wrap", int'(pulse_count), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule